// File: doc/BRIEF.md
# Split One-Time Protection Register

This block holds a 128-bit security register that is split into two 64-bit halves. The factory half is a unique number given as a parameter and fixed at reset. The user half starts blank and can be programmed one time, word by word. A program can only clear bits, never set them. A lock word sits beside the data. Clearing its user-lock bit freezes the user half until the next reset. The factory lock bit in the same word always reads as locked.

Software talks to the block through a command write port (`cmd_valid`, `cmd_addr`, `cmd_data`) and reads it through a combinational 16-bit read port addressed by word. A small controller has three states:

- **ARRAY**: the normal read mode. The read port returns zero.
- **IDENT**: the identification mode, in which the register is visible.
- **PSETUP**: a program command has been taken and the next write is its data.

The transitions are:

- ARRAY or IDENT to IDENT on 90h.
- ARRAY or IDENT to ARRAY on FFh.
- ARRAY or IDENT to PSETUP on C0h.
- PSETUP to IDENT on any write, which is taken as program data.
- In ARRAY or IDENT, 50h clears the error flag and leaves the state as it is. Any other code changes nothing.

Top module: `sec_otp_reg`

## Requirements
- R1: After reset the block is in ARRAY, every user word is FFFFh, the user lock is open and `prg_err` is 0.
- R2: The command code is `cmd_data[7:0]`. Code 90h selects IDENT and FFh selects ARRAY. In ARRAY `rd_data` is 0000h for every address. In any other state it shows the register.
- R3: Word address 80h reads as the lock word. Bit 0 is the factory lock and always reads 0. Bit 1 is the user lock, which reads 1 while open. All other bits read 1, so a fresh part reads FFFEh.
- R4: Addresses 81h to 84h return the factory words. 81h holds bits 15:0 of the factory number and 84h holds bits 63:48.
- R5: Addresses 85h to 88h return user words 0 to 3, and a blank word reads FFFFh.
- R6: A write with code C0h, then a write of address A and data D, replaces user word A with (word AND D). The new value is readable in the cycle after the data write, and the state is then IDENT.
- R7: Programming address 80h takes only bit 1 of the data. Once that bit is 0, the user lock stays closed until reset.
- R8: While the user lock is closed, programming a user word leaves it unchanged and sets `prg_err`.
- R9: Programming addresses 81h to 84h, or any address outside 80h to 88h, changes nothing and sets `prg_err`.
- R10: In IDENT, a read of any address outside 80h to 88h returns 0000h.
- R11: `prg_err` stays set until a 50h command, given outside PSETUP, clears it.
- R12: A code other than 90h, FFh, C0h or 50h leaves the state unchanged. In PSETUP a data write of FFh is program data, not a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command or data write strobe |
| cmd_addr | input | 8 | Word address of a program write |
| cmd_data | input | 16 | Command code in bits 7:0, or program data |
| rd_addr | input | 8 | Read word address |
| rd_data | output | 16 | Read data, combinational |
| prg_err | output | 1 | Sticky program error flag |

## Verification
If the controller is stuck in the wrong state, the very next read shows it. That read comes back as zero where register data was expected, or it shows data when zero was expected. It also shows up as a program that does not land in the cycle after its data write. A fault in the storage appears one cycle after the offending write, through the read port: a bit that returns to 1, a locked word that still changes, or a lock that reopens. A fault in the error logic appears on `prg_err` one cycle after a rejected write, or after the 50h clear command.

// File: rtl/sec_otp_pkg.sv
package sec_otp_pkg;

    typedef enum logic [1:0] {
        ST_ARRAY  = 2'd0,
        ST_IDENT  = 2'd1,
        ST_PSETUP = 2'd2
    } otp_state_e;

    localparam logic [7:0] CMD_IDENT = 8'h90;
    localparam logic [7:0] CMD_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_PSET  = 8'hC0;
    localparam logic [7:0] CMD_CLR   = 8'h50;

    // position of the user lock bit inside the lock word
    localparam int unsigned ULOCK_BIT = 1;

endpackage

// File: rtl/sec_otp_fsm.sv
module sec_otp_fsm
    import sec_otp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    output logic       id_mode,
    output logic       prog_stb,
    output logic       clr_stb
);

    otp_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARRAY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARRAY, ST_IDENT: begin
                if (cmd_valid) begin
                    case (cmd_code)
                        CMD_IDENT: state_d = ST_IDENT;
                        CMD_ARRAY: state_d = ST_ARRAY;
                        CMD_PSET:  state_d = ST_PSETUP;
                        default:   state_d = state_q;
                    endcase
                end
            end
            ST_PSETUP: begin
                if (cmd_valid) state_d = ST_IDENT;
            end
            default: state_d = ST_ARRAY;
        endcase
    end

    always_comb begin
        id_mode  = (state_q != ST_ARRAY);
        prog_stb = cmd_valid && (state_q == ST_PSETUP);
        clr_stb  = cmd_valid && (state_q != ST_PSETUP) && (cmd_code == CMD_CLR);
    end

endmodule

// File: rtl/sec_otp_store.sv
module sec_otp_store
    import sec_otp_pkg::*;
#(
    parameter int unsigned   DW   = 16,
    parameter int unsigned   NW   = 4,
    parameter int unsigned   AW   = 8,
    parameter logic [AW-1:0] BASE = 'h80
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   prog_stb,
    input  logic                   clr_stb,
    input  logic [AW-1:0]          prog_addr,
    input  logic [DW-1:0]          prog_data,
    output logic [NW-1:0][DW-1:0]  user_words,
    output logic                   ulock_open,
    output logic                   prg_err
);

    localparam logic [AW-1:0] USER_LO = AW'(NW + 1);
    localparam logic [AW-1:0] USER_HI = AW'(2 * NW);

    logic [AW-1:0] off;
    logic          hit_lock, hit_user, err_set;
    logic [DW-1:0] uw_q [NW];
    logic          ulock_q, err_q;

    assign off      = prog_addr - BASE;
    assign hit_lock = (off == '0);
    assign hit_user = (off >= USER_LO) && (off <= USER_HI);
    assign err_set  = prog_stb && !hit_lock && (!hit_user || !ulock_q);

    for (genvar i = 0; i < NW; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                uw_q[i] <= '1;
            else if (prog_stb && ulock_q && off == AW'(NW + 1 + i))
                uw_q[i] <= uw_q[i] & prog_data;
        end
        assign user_words[i] = uw_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                   ulock_q <= 1'b1;
        else if (prog_stb && hit_lock) ulock_q <= ulock_q & prog_data[ULOCK_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
        else if (clr_stb) err_q <= 1'b0;
    end

    assign ulock_open = ulock_q;
    assign prg_err    = err_q;

endmodule

// File: rtl/sec_otp_rdmux.sv
module sec_otp_rdmux
    import sec_otp_pkg::*;
#(
    parameter int unsigned       DW      = 16,
    parameter int unsigned       NW      = 4,
    parameter int unsigned       AW      = 8,
    parameter logic [AW-1:0]     BASE    = 'h80,
    parameter logic [NW*DW-1:0]  FACTORY = '0
) (
    input  logic                   id_mode,
    input  logic [AW-1:0]          rd_addr,
    input  logic [NW-1:0][DW-1:0]  user_words,
    input  logic                   ulock_open,
    output logic [DW-1:0]          rd_data
);

    logic [AW-1:0] off;
    logic [DW-1:0] lock_word;

    assign off = rd_addr - BASE;

    always_comb begin
        lock_word            = '1;
        lock_word[0]         = 1'b0;
        lock_word[ULOCK_BIT] = ulock_open;
    end

    always_comb begin
        rd_data = '0;
        if (id_mode) begin
            if (off == '0) rd_data = lock_word;
            for (int i = 0; i < NW; i++) begin
                if (off == AW'(i + 1))      rd_data = FACTORY[i*DW +: DW];
                if (off == AW'(NW + 1 + i)) rd_data = user_words[i];
            end
        end
    end

endmodule

// File: rtl/sec_otp_reg.sv
module sec_otp_reg
    import sec_otp_pkg::*;
#(
    parameter int unsigned       DW      = 16,
    parameter int unsigned       NW      = 4,
    parameter int unsigned       AW      = 8,
    parameter logic [AW-1:0]     BASE    = 'h80,
    parameter logic [NW*DW-1:0]  FACTORY = 64'h0123_4567_89AB_CDEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          prg_err
);

    logic                  id_mode, prog_stb, clr_stb, ulock_open;
    logic [NW-1:0][DW-1:0] user_words;

    sec_otp_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_code (cmd_data[7:0]),
        .id_mode  (id_mode),
        .prog_stb (prog_stb),
        .clr_stb  (clr_stb)
    );

    sec_otp_store #(.DW(DW), .NW(NW), .AW(AW), .BASE(BASE)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_stb  (prog_stb),
        .clr_stb   (clr_stb),
        .prog_addr (cmd_addr),
        .prog_data (cmd_data),
        .user_words(user_words),
        .ulock_open(ulock_open),
        .prg_err   (prg_err)
    );

    sec_otp_rdmux #(.DW(DW), .NW(NW), .AW(AW), .BASE(BASE), .FACTORY(FACTORY)) u_rd (
        .id_mode   (id_mode),
        .rd_addr   (rd_addr),
        .user_words(user_words),
        .ulock_open(ulock_open),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/sec_otp_reg_chk.sv
module sec_otp_reg_chk #(
    parameter int unsigned   DW   = 16,
    parameter int unsigned   NW   = 4,
    parameter int unsigned   AW   = 8,
    parameter logic [AW-1:0] BASE = 'h80
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  id_mode,
    input logic                  prog_stb,
    input logic                  clr_stb,
    input logic [AW-1:0]         prog_addr,
    input logic [AW-1:0]         rd_addr,
    input logic [DW-1:0]         rd_data,
    input logic                  ulock_open,
    input logic                  prg_err,
    input logic [NW-1:0][DW-1:0] user_words
);

    localparam logic [AW-1:0] FACT_HI = AW'(BASE + NW);
    localparam logic [AW-1:0] TOP_ADR = AW'(BASE + 2 * NW);

    a_r2_array_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> rd_data == '0);

    a_r6_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (user_words & ~$past(user_words)) == '0);

    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !ulock_open |=> !ulock_open);

    a_r8_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb && !ulock_open |=> $stable(user_words));

    a_r9_factory_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb && prog_addr > BASE && prog_addr <= FACT_HI |=> prg_err);

    a_r10_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        id_mode && (rd_addr < BASE || rd_addr > TOP_ADR) |-> rd_data == '0);

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        prg_err && !clr_stb |=> prg_err);

endmodule

bind sec_otp_reg sec_otp_reg_chk #(.DW(DW), .NW(NW), .AW(AW), .BASE(BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_mode   (id_mode),
    .prog_stb  (prog_stb),
    .clr_stb   (clr_stb),
    .prog_addr (cmd_addr),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .ulock_open(ulock_open),
    .prg_err   (prg_err),
    .user_words(user_words)
);

// File: tb/sec_otp_reg_test.sv
module sec_otp_reg_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] FACT       = 64'h0123_4567_89AB_CDEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        prg_err;

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    int          m_mode;   // 0 array, 1 ident, 2 program setup
    logic [15:0] m_user [4];
    logic        m_open;
    logic        m_err;

    sec_otp_reg #(.FACTORY(FACT)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .prg_err  (prg_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual running expected done");
        summary();
    end

    function automatic void model_reset();
        m_mode = 0;
        m_open = 1'b1;
        m_err  = 1'b0;
        for (int i = 0; i < 4; i++) m_user[i] = 16'hFFFF;
    endfunction

    function automatic void model_apply(logic [7:0] a, logic [15:0] d);
        logic [7:0] off;
        off = a - 8'h80;
        if (m_mode == 2) begin
            m_mode = 1;
            if (off == 0) m_open = m_open & d[1];
            else if (off >= 5 && off <= 8) begin
                if (!m_open) m_err = 1'b1;
                else m_user[off - 5] = m_user[off - 5] & d;
            end else m_err = 1'b1;
        end else begin
            case (d[7:0])
                8'h90: m_mode = 1;
                8'hFF: m_mode = 0;
                8'hC0: m_mode = 2;
                8'h50: m_err = 1'b0;
                default: ;
            endcase
        end
    endfunction

    function automatic logic [15:0] exp_read(logic [7:0] a);
        logic [7:0] off;
        off = a - 8'h80;
        if (m_mode == 0) return 16'h0000;
        if (off == 0) return {14'h3FFF, m_open, 1'b0};
        if (off >= 1 && off <= 4) return FACT[(off - 1) * 16 +: 16];
        if (off >= 5 && off <= 8) return m_user[off - 5];
        return 16'h0000;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_addr  = a;
        cmd_data  = d;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        model_apply(a, d);
    endtask

    task automatic chk_rd(logic [7:0] a, string req);
        logic [15:0] e;
        @(negedge clk);
        rd_addr = a;
        #1;
        e = exp_read(a);
        n_chk++;
        if (rd_data !== e) begin
            n_fail++;
            $display("FAIL %s: read %h actual %h expected %h", req, a, rd_data, e);
        end
    endtask

    task automatic chk_err(string req);
        @(negedge clk);
        #1;
        n_chk++;
        if (prg_err !== m_err) begin
            n_fail++;
            $display("FAIL %s: prg_err actual %b expected %b", req, prg_err, m_err);
        end
    endtask

    initial begin
        logic [7:0] codes [4];
        codes = '{8'h00, 8'h20, 8'h70, 8'hD0};
        void'($urandom(32'd7));
        model_reset();
        do_reset();

        chk_rd(8'h80, "R1");
        chk_err("R1");
        wr(8'h00, 16'h0090);
        chk_rd(8'h80, "R3");
        for (int a = 8'h81; a <= 8'h84; a++) chk_rd(8'(a), "R4");
        for (int a = 8'h85; a <= 8'h88; a++) chk_rd(8'(a), "R5");
        chk_rd(8'h89, "R10");
        chk_rd(8'h7F, "R10");
        chk_rd(8'h00, "R10");
        wr(8'h00, 16'h00FF);
        chk_rd(8'h81, "R2");
        wr(8'h00, 16'h0012);
        chk_rd(8'h81, "R12");
        wr(8'h00, 16'h0090);
        wr(8'h00, 16'h0033);
        chk_rd(8'h82, "R12");
        wr(8'h00, 16'h00C0);
        wr(8'h85, 16'hF0F0);
        chk_rd(8'h85, "R6");
        wr(8'h00, 16'h00C0);
        wr(8'h85, 16'hFF0F);
        chk_rd(8'h85, "R6");
        wr(8'h00, 16'h00C0);
        wr(8'h86, 16'h00FF);
        chk_rd(8'h86, "R12");
        chk_rd(8'h81, "R12");
        wr(8'h00, 16'h00C0);
        wr(8'h82, 16'h0000);
        chk_rd(8'h82, "R9");
        chk_err("R9");
        wr(8'h00, 16'h0012);
        chk_err("R11");
        wr(8'h00, 16'h0050);
        chk_err("R11");
        wr(8'h00, 16'h00C0);
        wr(8'h9A, 16'h0000);
        chk_err("R9");
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h00C0);
        wr(8'h80, 16'hFFFD);
        chk_rd(8'h80, "R7");
        wr(8'h00, 16'h00C0);
        wr(8'h87, 16'h0000);
        chk_rd(8'h87, "R8");
        chk_err("R8");
        wr(8'h00, 16'h00C0);
        wr(8'h80, 16'hFFFF);
        chk_rd(8'h80, "R7");

        do_reset();
        wr(8'h00, 16'h0090);
        chk_rd(8'h80, "R1");
        chk_rd(8'h87, "R1");

        for (int it = 0; it < 400; it++) begin
            int unsigned r;
            logic [7:0]  a;
            logic [15:0] d;
            r = $urandom % 8;
            case (r)
                0: wr(8'h00, 16'h0090);
                1: wr(8'h00, 16'h00FF);
                2: wr(8'h00, 16'h0050);
                3: wr(8'h00, {8'h00, codes[$urandom % 4]});
                4, 5, 6: begin
                    wr(8'h00, 16'h00C0);
                    a = 8'(8'h7F + ($urandom % 11));
                    if (a == 8'h80) d = ($urandom % 6 == 0) ? 16'hFFFD : 16'hFFFF;
                    else            d = 16'($urandom) | 16'($urandom);
                    wr(a, d);
                end
                default: ;
            endcase
            chk_rd(8'(8'h7C + ($urandom % 16)), "R6");
            chk_err("R11");
        end

        summary();
    end

endmodule